// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a parallel-in, serial-out shift register with a parameterised number of stages (eight by default). All of its external controls are sampled by a single system clock. Holding the active-low load input low copies the parallel word into the stages on every system clock edge. Otherwise the register shifts one stage toward its last stage each time the combined shift clock rises. The combined shift clock is the OR of a shift-clock input and an inhibit input, and the two inputs can swap roles. While either input is held high, the other cannot produce a shift.

The shift-clock and inhibit inputs pass through two-flop synchronizers. A rising edge is detected between consecutive synchronized samples of their OR. The last stage drives a serial output, and a separate register drives its complement. The parallel and serial data inputs are not synchronized. They are sampled in the system cycle in which the load or shift takes effect. Every data pin here is a plain level, so no valid/ready handshake applies: the serial output is a continuously valid level and cannot be back-pressured.

Top module: `plsr_top`

## Requirements
- R1: Synchronous active-high reset clears every stage, so serial_q reads 0 and serial_qn reads 1. No shift is detected after reset is released, even when the shift clock is held high through reset.
- R2: While load_n is low, every system clock edge copies par_d into the stages, whatever the levels of shift_clk, shift_inh and ser_d. Bit par_d[i] goes to stage i, and par_d[WIDTH-1] is the last stage shown on serial_q.
- R3: When load_n is low in the same cycle as a detected combined-clock rise, the load takes effect and the shift is dropped. That rise does not cause a later shift.
- R4: On a shift, stage i+1 takes the old value of stage i, and stage 0 takes ser_d. A bit entered on ser_d appears on serial_q after WIDTH shifts.
- R5: A rise of shift_clk while shift_inh is low causes one shift. A rise of shift_inh while shift_clk is low also causes one shift.
- R6: While shift_clk or shift_inh is held high, the contents hold. Toggling the other input produces no shift, and neither does lowering both inputs.
- R7: When shift_clk rises just before system edge k, the shift is applied at edge k+2. serial_q is unchanged after edges k and k+1 and shows the new value after edge k+2.
- R8: serial_qn is always the logical complement of serial_q.
- R9: After loading par_d = 8'hD5 (bit 0 = 1, bit 1 = 0, alternating, bit 7 = 1), serial_q shows 1, then 1, 0, 1, 0, 1, 0, 1 after successive shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low level load select |
| shift_clk | input | 1 | Shift clock input, asynchronous |
| shift_inh | input | 1 | Inhibit input, interchangeable with shift_clk, asynchronous |
| ser_d | input | 1 | Serial data entering stage 0 |
| par_d | input | WIDTH | Parallel data, bit i to stage i |
| serial_q | output | 1 | Last stage, registered |
| serial_qn | output | 1 | Complement of the last stage, registered |

## Verification
Only the last stage is visible, so a wrong bit in an inner stage stays hidden until enough shifts move it to serial_q. That takes up to WIDTH-1 combined-clock rises, so the tests shift whole words out. A false edge after reset or after a dropped shift shows up as a one-stage offset in the bits that follow. A wrong synchronizer depth shows up as a shift arriving one cycle early or late relative to edge k+2. A broken complement register is visible at once on serial_qn.

// File: rtl/plsr_pkg.sv
package plsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } plsr_op_e;
endpackage

// File: rtl/plsr_sync.sv
module plsr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/plsr_edge.sv
module plsr_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic inh_s,
  output logic rise
);
  logic comb_now;
  logic comb_prev;

  assign comb_now = clk_s | inh_s;

  always_ff @(posedge clk) begin
    if (rst) comb_prev <= 1'b1;
    else     comb_prev <= comb_now;
  end

  assign rise = comb_now & ~comb_prev;

  AST_NO_EDGE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rise); // R1
  AST_HELD_HIGH_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($past(clk_s) && clk_s) || ($past(inh_s) && inh_s) |-> !rise); // R6
endmodule

// File: rtl/plsr_stages.sv
module plsr_stages
  import plsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  plsr_op_e         op,
  input  logic [WIDTH-1:0] par_d,
  input  logic             ser_d,
  output logic             last_q,
  output logic             last_qn
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] st_q;
  logic [WIDTH-1:0] st_d;
  logic             qn_q;

  always_comb begin
    unique case (op)
      OP_LOAD:  st_d = par_d;
      OP_SHIFT: st_d = {st_q[LAST-1:0], ser_d};
      default:  st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      qn_q <= 1'b1;
    end else begin
      st_q <= st_d;
      qn_q <= ~st_d[LAST];
    end
  end

  assign last_q  = st_q[LAST];
  assign last_qn = qn_q;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> last_q == $past(par_d[LAST])); // R2
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    op == OP_SHIFT |=> st_q[0] == $past(ser_d)); // R4
  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    op == OP_SHIFT |=> last_q == $past(st_q[LAST-1])); // R4
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    last_qn != last_q); // R8
endmodule

// File: rtl/plsr_top.sv
module plsr_top
  import plsr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             shift_clk,
  input  logic             shift_inh,
  input  logic             ser_d,
  input  logic [WIDTH-1:0] par_d,
  output logic             serial_q,
  output logic             serial_qn
);
  logic     clk_s;
  logic     inh_s;
  logic     rise;
  plsr_op_e op;

  plsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst(rst), .d(shift_clk), .q(clk_s)
  );
  plsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_inh (
    .clk(clk), .rst(rst), .d(shift_inh), .q(inh_s)
  );

  plsr_edge u_edge (
    .clk(clk), .rst(rst), .clk_s(clk_s), .inh_s(inh_s), .rise(rise)
  );

  always_comb begin
    if (!load_n)   op = OP_LOAD;
    else if (rise) op = OP_SHIFT;
    else           op = OP_HOLD;
  end

  plsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk(clk), .rst(rst), .op(op), .par_d(par_d), .ser_d(ser_d),
    .last_q(serial_q), .last_qn(serial_qn)
  );

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (!load_n && rise) |=> serial_q == $past(par_d[WIDTH-1])); // R3
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (load_n && !rise) |=> $stable(serial_q)); // R6
endmodule

// File: tb/plsr_top_bench.sv
`timescale 1ns/1ps
module plsr_top_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_n = 1'b1;
  logic         shift_clk = 1'b0;
  logic         shift_inh = 1'b0;
  logic         ser_d = 1'b0;
  logic [W-1:0] par_d = '0;
  logic         serial_q;
  logic         serial_qn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  plsr_top #(.WIDTH(W)) u_plsr_top (
    .clk(clk), .rst(rst), .load_n(load_n), .shift_clk(shift_clk),
    .shift_inh(shift_inh), .ser_d(ser_d), .par_d(par_d),
    .serial_q(serial_q), .serial_qn(serial_qn)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
    checks++;
    if (serial_qn !== ~serial_q) begin
      errors++;
      $display("FAIL R8: serial_qn %b expected %b at %0t", serial_qn, ~serial_q, $time);
    end
  endtask

  task automatic pulse();
    shift_clk = 1'b1; step(4);
    shift_clk = 1'b0; step(4);
  endtask

  task automatic load_word(input logic [W-1:0] w);
    par_d = w; load_n = 1'b0; step(2);
    load_n = 1'b1; step(1);
  endtask

  task automatic t_reset();
    rst = 1'b1; shift_clk = 1'b1; ser_d = 1'b1; step(3);
    rst = 1'b0; step(1);
    chk(serial_q, 1'b0, "R1 reset value");
    step(6);
    ser_d = 1'b0; shift_clk = 1'b0; step(4);
    for (int i = 0; i < W - 1; i++) pulse();
    chk(serial_q, 1'b0, "R1 no false edge after reset");
  endtask

  task automatic t_pattern();
    logic [W-2:0] exp;
    exp = 7'b1010101;
    par_d = 8'hD5; load_n = 1'b0;
    shift_clk = 1'b1; step(4); shift_clk = 1'b0; step(4);
    load_n = 1'b1; step(1);
    chk(serial_q, 1'b1, "R2/R9 loaded last stage");
    for (int i = 0; i < W - 1; i++) begin
      pulse();
      chk(serial_q, exp[W-2-i], "R9 shifted sequence");
    end
  endtask

  task automatic t_latency();
    load_word(8'h40);
    shift_clk = 1'b1;
    step(1); chk(serial_q, 1'b0, "R7 edge k unchanged");
    step(1); chk(serial_q, 1'b0, "R7 edge k+1 unchanged");
    step(1); chk(serial_q, 1'b1, "R7 edge k+2 shifted");
    shift_clk = 1'b0; step(4);
  endtask

  task automatic t_serial();
    load_word(8'h00);
    ser_d = 1'b1; pulse(); ser_d = 1'b0;
    for (int i = 0; i < W - 2; i++) pulse();
    chk(serial_q, 1'b0, "R4 serial bit not yet out");
    pulse();
    chk(serial_q, 1'b1, "R4 serial bit after WIDTH shifts");
  endtask

  task automatic t_inhibit_clock();
    load_word(8'h7F);
    shift_inh = 1'b1; step(4);
    chk(serial_q, 1'b1, "R5 inhibit rise shifts");
    shift_inh = 1'b0; step(4);
    shift_clk = 1'b1; step(4);
    chk(serial_q, 1'b1, "R5 clock rise shifts");
    shift_clk = 1'b0; step(4);
  endtask

  task automatic t_hold();
    load_word(8'h55);
    shift_clk = 1'b1; step(4);
    chk(serial_q, 1'b1, "R5 first shift");
    shift_inh = 1'b1; step(4);
    shift_inh = 1'b0; step(4);
    shift_inh = 1'b1; step(4);
    chk(serial_q, 1'b1, "R6 clock high, inhibit toggles");
    shift_clk = 1'b0; step(4);
    shift_clk = 1'b1; step(4);
    shift_clk = 1'b0; step(4);
    chk(serial_q, 1'b1, "R6 inhibit high, clock toggles");
    shift_inh = 1'b0; step(4);
    chk(serial_q, 1'b1, "R6 both low, no shift");
    pulse();
    chk(serial_q, 1'b0, "R6 contents intact");
  endtask

  task automatic t_load_wins();
    load_word(8'h00);
    par_d = 8'h80; load_n = 1'b0; shift_clk = 1'b1;
    step(3);
    load_n = 1'b1; par_d = 8'h00;
    step(1);
    chk(serial_q, 1'b1, "R3 load wins over coincident rise");
    shift_clk = 1'b0; step(4);
    chk(serial_q, 1'b1, "R3 no delayed shift");
    pulse();
    chk(serial_q, 1'b0, "R3 next shift normal");
  endtask

  initial begin
    t_reset();
    t_pattern();
    t_latency();
    t_serial();
    t_inhibit_clock();
    t_hold();
    t_load_wins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule